// File: doc/BRIEF.md
# Selectable-clock 8-bit overflow timer

This block is an up-counter that moves forward by one whenever the selected timer tick is present. A three-bit source field picks the tick. The source can be stopped, the system clock, one of four divided-clock enable strobes arriving from an external prescaler, or a synchronized falling or rising edge on an external pin. The tick only enables the register. The whole block runs on the single system clock.

Software-style write strobes load the count and the control field. The current values appear on read outputs. When the count rolls over from its top value to zero, a sticky overflow flag is set. An interrupt request follows the flag when the interrupt-enable bit is set. An acknowledge input clears the flag.

Top module: `ovf_timer`

## Requirements
- R1: After reset the count, source field, interrupt enable, overflow flag and interrupt request are all zero.
- R2: With source code 0 the count holds its value whatever the strobes and pin do. A count write still loads the count.
- R3: Source code 1 advances the count on every clock. Codes 2, 3, 4 and 5 advance it only on a clock where `tap_div8`, `tap_div64`, `tap_div256` or `tap_div1024` respectively is high, and the other strobes have no effect.
- R4: The pin passes through two synchronizing flops before edge detection. Code 7 counts rising edges and code 6 counts falling edges. The count changes on the third rising clock edge after the pin changes, and edges of the other polarity are not counted.
- R5: The count only increments. From the all-ones value it wraps to zero.
- R6: The overflow flag is set by the clock edge on which an increment takes the count from all-ones to zero. A write that loads zero does not set it.
- R7: When `wr_cnt` is high the count takes `wdata` at the next clock edge, even if a tick is present. Such a cycle causes no overflow.
- R8: The overflow flag stays set until `irq_ack` is high. It then clears at the next clock edge, unless an overflow occurs in that same cycle, in which case it stays set.
- R9: `irq` is high exactly while the overflow flag and the interrupt-enable bit are both set.
- R10: `wr_ctl` loads the source field from `wdata[2:0]` and the interrupt enable from `wdata[3]`. The new source takes effect from the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_cnt | input | 1 | Load count from `wdata` |
| wr_ctl | input | 1 | Load source field and interrupt enable from `wdata` |
| wdata | input | CW | Write data |
| tap_div8 | input | 1 | Prescaler enable strobe, clock/8 |
| tap_div64 | input | 1 | Prescaler enable strobe, clock/64 |
| tap_div256 | input | 1 | Prescaler enable strobe, clock/256 |
| tap_div1024 | input | 1 | Prescaler enable strobe, clock/1024 |
| ext_pin | input | 1 | External count pin, asynchronous |
| irq_ack | input | 1 | Clears the overflow flag |
| cnt_o | output | CW | Current count |
| sel_o | output | 3 | Current source field |
| ien_o | output | 1 | Current interrupt enable |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
Every source code is run against the same free-running set of strobes, in which all four dividers pulse at their own rates. The bench counts the expected ticks arithmetically, so a wrong multiplexer leg or a strobe leaking into another code shows up as a wrong final count. The start values are chosen so that most runs cross the wrap and one does not, which separates a flag set on overflow from a flag that is never set or always set. Pin pulses are counted per polarity, and one edge is timed clock by clock to pin the synchronizer depth. Directed cases collide a write or an acknowledge with a rollover.

// File: rtl/ovf_timer.sv
module ovf_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cnt,
  input  logic          wr_ctl,
  input  logic [CW-1:0] wdata,
  input  logic          tap_div8,
  input  logic          tap_div64,
  input  logic          tap_div256,
  input  logic          tap_div1024,
  input  logic          ext_pin,
  input  logic          irq_ack,
  output logic [CW-1:0] cnt_o,
  output logic [2:0]    sel_o,
  output logic          ien_o,
  output logic          ovf_flag,
  output logic          irq
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [2:0] pin_q;
  logic       pin_rise, pin_fall, tick, wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= {pin_q[1:0], ext_pin};
  end

  assign pin_rise = pin_q[1] & ~pin_q[2];
  assign pin_fall = ~pin_q[1] & pin_q[2];

  always_comb begin
    case (sel_o)
      3'd1:    tick = 1'b1;
      3'd2:    tick = tap_div8;
      3'd3:    tick = tap_div64;
      3'd4:    tick = tap_div256;
      3'd5:    tick = tap_div1024;
      3'd6:    tick = pin_fall;
      3'd7:    tick = pin_rise;
      default: tick = 1'b0;
    endcase
  end

  assign wrap = tick & ~wr_cnt & (cnt_o == CMAX);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_o <= '0;
    else if (wr_cnt) cnt_o <= wdata;
    else if (tick)   cnt_o <= cnt_o + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_o <= '0;
      ien_o <= 1'b0;
    end else if (wr_ctl) begin
      sel_o <= wdata[2:0];
      ien_o <= wdata[3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_flag <= 1'b0;
    else        ovf_flag <= wrap | (ovf_flag & ~irq_ack);
  end

  assign irq = ovf_flag & ien_o;
endmodule

// File: rtl/ovf_timer_sva.sv
module ovf_timer_sva #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_cnt,
  input logic [CW-1:0] wdata,
  input logic          irq_ack,
  input logic [CW-1:0] cnt,
  input logic [2:0]    sel,
  input logic          ien,
  input logic          flag,
  input logic          irq
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0 && !wr_cnt) |=> $stable(cnt));

  a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt == $past(wdata));

  a_r5_only_up: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt |=> (cnt == $past(cnt) || cnt == CW'($past(cnt) + 1'b1)));

  a_r6_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && sel == 3'd1 && cnt == CMAX) |=> flag);

  a_r6_write_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && !flag) |=> !flag);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !irq_ack) |=> flag);

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !(cnt == CMAX && sel != 3'd0)) |=> !flag);

  a_r9_irq_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && ien));
endmodule

bind ovf_timer ovf_timer_sva #(.CW(CW)) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_cnt(wr_cnt), .wdata(wdata), .irq_ack(irq_ack),
  .cnt(cnt_o), .sel(sel_o), .ien(ien_o), .flag(ovf_flag), .irq(irq)
);

// File: tb/sim_ovf_timer.sv
`timescale 1ns/1ps
module sim_ovf_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_cnt = 1'b0, wr_ctl = 1'b0, irq_ack = 1'b0, ext_pin = 1'b0;
  logic [7:0] wdata = '0;
  logic       t8 = 1'b0, t64 = 1'b0, t256 = 1'b0, t1024 = 1'b0;
  logic [7:0] cnt_o;
  logic [2:0] sel_o;
  logic       ien_o, ovf_flag, irq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ovf_timer #(.CW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_cnt(wr_cnt), .wr_ctl(wr_ctl), .wdata(wdata),
    .tap_div8(t8), .tap_div64(t64), .tap_div256(t256), .tap_div1024(t1024),
    .ext_pin(ext_pin), .irq_ack(irq_ack), .cnt_o(cnt_o), .sel_o(sel_o),
    .ien_o(ien_o), .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [3:0] v);
    @(negedge clk); wdata = {4'd0, v}; wr_ctl = 1'b1;
    @(negedge clk); wr_ctl = 1'b0;
  endtask

  task automatic set_cnt(input logic [7:0] v);
    @(negedge clk); wdata = v; wr_cnt = 1'b1;
    @(negedge clk); wr_cnt = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic run_src(input string req, input int sel, input int start, input int len);
    int n;
    set_ctl(4'd0); ack(); set_cnt(8'(start)); set_ctl(4'(sel));
    n = (sel == 1) ? 1 : 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      t8 = (i % 8 == 0); t64 = (i % 64 == 0);
      t256 = (i % 256 == 0); t1024 = (i % 1024 == 0);
      case (sel)
        1: n++;
        2: if (t8) n++;
        3: if (t64) n++;
        4: if (t256) n++;
        5: if (t1024) n++;
        default: ;
      endcase
    end
    @(negedge clk); {t8, t64, t256, t1024} = '0;
    chk({req, " count"}, cnt_o, (start + n) % 256);
    chk({req, " flag"}, ovf_flag, (start + n) > 255);
  endtask

  task automatic run_pin(input string req, input int sel, input int start, input int pulses);
    set_ctl(4'd0); ack(); set_cnt(8'(start)); set_ctl(4'(sel));
    for (int k = 0; k < pulses; k++) begin
      @(negedge clk); ext_pin = 1'b1;
      repeat (4) @(negedge clk);
      ext_pin = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk({req, " pin count"}, cnt_o, (start + pulses) % 256);
    chk({req, " pin flag"}, ovf_flag, (start + pulses) > 255);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cnt", cnt_o, 0); chk("R1 sel", sel_o, 0); chk("R1 ien", ien_o, 0);
    chk("R1 flag", ovf_flag, 0); chk("R1 irq", irq, 0);

    // R2: stopped, strobes and pin wiggle, count holds, write still loads
    set_cnt(8'h5A);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); {t8, t64, t256, t1024} = 4'hF; ext_pin = i[2];
    end
    @(negedge clk); {t8, t64, t256, t1024} = '0; ext_pin = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 hold", cnt_o, 8'h5A);
    set_cnt(8'hC3);
    chk("R2 write while stopped", cnt_o, 8'hC3);

    // R3/R5/R6: source sweep with all strobes running
    run_src("R3 sel1", 1, 8'hF0, 300);
    run_src("R3 sel2", 2, 0, 2100);
    run_src("R3 sel3", 3, 8'hE0, 2100);
    run_src("R3 sel4", 4, 8'hF8, 2100);
    run_src("R3 sel5", 5, 8'hFE, 2100);
    run_src("R3 sel5 no wrap", 5, 0, 2100);

    // R5/R6: exact wrap
    set_ctl(4'd0); ack(); set_cnt(8'hFE); set_ctl(4'd1);
    chk("R5 at FE", cnt_o, 8'hFE); chk("R6 flag before", ovf_flag, 0);
    @(negedge clk); chk("R5 at FF", cnt_o, 8'hFF); chk("R6 flag at FF", ovf_flag, 0);
    @(negedge clk); chk("R5 wrap", cnt_o, 8'h00); chk("R6 flag on wrap", ovf_flag, 1);
    @(negedge clk); chk("R5 after wrap", cnt_o, 8'h01); chk("R8 sticky", ovf_flag, 1);

    // R8: ack with simultaneous overflow keeps flag
    set_ctl(4'd0); set_cnt(8'hFF); set_ctl(4'd1);
    irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R8 ack+overflow cnt", cnt_o, 0); chk("R8 ack+overflow flag", ovf_flag, 1);
    ack();
    chk("R8 ack clears", ovf_flag, 0);

    // R6: write of zero does not set flag
    set_ctl(4'd0); set_cnt(8'hFF); set_cnt(8'h00);
    chk("R6 write zero", ovf_flag, 0);

    // R7: write collides with tick at all-ones
    set_ctl(4'd1);
    @(negedge clk); wdata = 8'hFF; wr_cnt = 1'b1;
    @(negedge clk); wdata = 8'h33;
    @(negedge clk); wr_cnt = 1'b0;
    chk("R7 write wins", cnt_o, 8'h33); chk("R7 no overflow", ovf_flag, 0);
    @(negedge clk); chk("R7 resumes", cnt_o, 8'h34);

    // R9/R10: interrupt request and control read-back
    set_ctl(4'd0); set_cnt(8'hFF); set_ctl(4'd1);
    @(negedge clk);
    chk("R9 flag set", ovf_flag, 1); chk("R9 irq masked", irq, 0);
    set_ctl(4'b1001);
    chk("R10 sel", sel_o, 1); chk("R10 ien", ien_o, 1); chk("R9 irq on", irq, 1);
    ack();
    chk("R9 irq off", irq, 0);
    set_ctl(4'b1110);
    chk("R10 sel6", sel_o, 6); chk("R10 ien kept", ien_o, 1);

    // R4: rising-edge latency, then other polarity ignored
    set_ctl(4'd0); set_cnt(8'h10); set_ctl(4'd7);
    @(negedge clk); ext_pin = 1'b1;
    @(negedge clk); chk("R4 edge +1", cnt_o, 8'h10);
    @(negedge clk); chk("R4 edge +2", cnt_o, 8'h10);
    @(negedge clk); chk("R4 edge +3", cnt_o, 8'h11);
    ext_pin = 1'b0;
    repeat (6) @(negedge clk);
    chk("R4 falling ignored", cnt_o, 8'h11);
    run_pin("R4 rise", 7, 8'hF0, 20);
    run_pin("R4 fall", 6, 8'h05, 12);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule